// File: doc/BRIEF.md
# Audio Sample FIFO Controller

This block buffers audio samples between a host bus and a serial audio link. A transmit queue of 32-bit words is filled by the host and drained by a serializer, one word per pop strobe. A receive queue is filled by a deserializer and drained by the host. A single set of registers reports how much space is free in the transmit queue and how many words are waiting in the receive queue. A programmable transmit threshold drives a "transmit needs data" status. The block raises an interrupt line and two DMA request lines from those conditions.

The host talks to the block through a plain strobe interface: `bus_wr` or `bus_rd` for one cycle with a 3-bit register index. Read data comes back registered one cycle later and holds until the next read. Interrupt status bits are sticky and are cleared by writing 1 to them. A clear has no effect while the condition behind a level-type bit is still true. Each queue has its own flush bit, which empties the queue for as long as the bit is set. Two free-running sample counters count the words consumed by the serializer and accepted from the deserializer. Any write to a counter sets it to zero.

Register index map: 0 control, 1 levels, 2 interrupt status, 3 enables, 4 transmit data (write), 5 receive data (read), 6 transmit sample counter, 7 receive sample counter.

Top module: `audio_fifo_ctrl`

## Requirements
- R1: After reset the control register reads 0x00040000, the levels register reads 0x00400000, the enable register reads 0, and `irq`, `tx_dreq`, `rx_dreq` are 0.
- R2: Words written to index 4 leave on `ser_word` in write order. Each word is valid the cycle after its `ser_pop` strobe. The free count in levels bits 23:16 drops by one per accepted write.
- R3: Words pushed with `des_push` are returned in order by reads of index 5. The waiting count is in levels bits 5:0.
- R4: Status bit 4 (transmit needs data) is set whenever the free count is at or above the threshold. Writing 1 to it clears it only when the free count is below the threshold.
- R5: Status bit 0 (receive data waiting) is set whenever the receive queue is non-empty. Writing 1 to it clears it only once the queue is empty.
- R6: A `ser_pop` while the transmit queue is empty or flushing returns 0 on `ser_word`. It also sets sticky status bit 6 (underrun), which is cleared by writing 1.
- R7: A transmit-data write while the transmit queue is full is dropped and sets sticky bit 5. A receive-data read while the receive queue is empty returns 0, pops nothing and sets sticky bit 1. Both bits clear when 1 is written to them.
- R8: Control bit 25 empties the transmit queue and control bit 24 empties the receive queue, for as long as each bit is set.
- R9: `irq` is 1 exactly when some status bit among 0, 4 and 6 is set together with the enable bit at the same position.
- R10: `tx_dreq` follows enable bit 7 ANDed with the free count being at or above the threshold. `rx_dreq` follows enable bit 3 ANDed with a non-empty receive queue. Enable bits 1, 2 and 5 read as 0.
- R11: Index 6 counts words the serializer took and index 7 counts words accepted from the deserializer. Any write to either index sets that counter to 0.
- R12: Control bits 18:12 hold the 7-bit transmit threshold, which resets to 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered host read data |
| ser_pop | input | 1 | Serializer takes one transmit word |
| ser_word | output | 32 | Word delivered to the serializer |
| des_push | input | 1 | Deserializer delivers one receive word |
| des_word | input | 32 | Receive word |
| irq | output | 1 | Interrupt request |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |

## Verification
The queues are driven with short bursts of distinct words, with a fill to the last slot followed by one extra write, and with a drain past empty. Ordering, the full boundary and the empty boundary each show up as distinct values on `ser_word` and in the levels fields. The threshold is tried at its reset value and at one below the depth. At the lower threshold a single queued word keeps bit 4 set against a clear, and a second word lets the clear take effect. Interrupt and DMA lines are checked with one enable at a time, so that each status bit's path to `irq` is seen in isolation.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_LVL   = 3'd1,
    A_ISTAT = 3'd2,
    A_IEN   = 3'd3,
    A_TXD   = 3'd4,
    A_RXD   = 3'd5,
    A_TXC   = 3'd6,
    A_RXC   = 3'd7
  } reg_idx_e;

  // status / enable bit positions
  localparam int B_RXA   = 0;
  localparam int B_RXERR = 1;
  localparam int B_RXDRQ = 3;
  localparam int B_TXE   = 4;
  localparam int B_TXERR = 5;
  localparam int B_TXUR  = 6;
  localparam int B_TXDRQ = 7;
  localparam int ST_W    = 7;

  localparam logic [ST_W-1:0] IRQ_MASK = 7'b101_0001;
  localparam logic [7:0]      EN_MASK  = 8'hD9;

  // control fields
  localparam int THR_LSB = 12;
  localparam int THR_W   = 7;
  localparam int FL_RX   = 24;
  localparam int FL_TX   = 25;
  localparam logic [THR_W-1:0] THR_RST = 7'h40;

  // level fields
  localparam int TXF_W = 8;
  localparam int RXA_W = 6;
endpackage

// File: rtl/afifo_buf.sv
module afifo_buf #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (level == CW'(DEPTH)));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/afifo_irq.sv
module afifo_irq
  import afifo_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            txe_cond,
  input  logic            rxa_cond,
  input  logic            rx_err_evt,
  input  logic            tx_err_evt,
  input  logic            tx_ur_evt,
  input  logic            clr_we,
  input  logic [ST_W-1:0] clr_bits,
  input  logic [7:0]      en,
  output logic [ST_W-1:0] st,
  output logic            irq,
  output logic            tx_dreq,
  output logic            rx_dreq
);
  logic [ST_W-1:0] set_v, clr_v, st_nxt;

  always_comb begin
    set_v          = '0;
    set_v[B_RXA]   = rxa_cond;
    set_v[B_RXERR] = rx_err_evt;
    set_v[B_TXE]   = txe_cond;
    set_v[B_TXERR] = tx_err_evt;
    set_v[B_TXUR]  = tx_ur_evt;
    clr_v  = clr_we ? clr_bits : '0;
    st_nxt = (st & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= '0;
      irq     <= 1'b0;
      tx_dreq <= 1'b0;
      rx_dreq <= 1'b0;
    end else begin
      st      <= st_nxt;
      irq     <= |(st_nxt & en[ST_W-1:0] & IRQ_MASK);
      tx_dreq <= en[B_TXDRQ] && txe_cond;
      rx_dreq <= en[B_RXDRQ] && rxa_cond;
    end
  end

  // R4
  txe_set_chk: assert property (@(posedge clk) disable iff (rst)
    txe_cond |=> st[B_TXE]);

  // R6
  underrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ur_evt |=> st[B_TXUR]);

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    (st[B_TXUR] && en[B_TXUR]) |-> irq);

  // R10
  rx_dreq_chk: assert property (@(posedge clk) disable iff (rst)
    (en[B_RXDRQ] && rxa_cond) |=> rx_dreq);
endmodule

// File: rtl/audio_fifo_ctrl.sv
module audio_fifo_ctrl
  import afifo_pkg::*;
#(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 32,
  parameter int CNT_W    = 32,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ser_pop,
  output logic [DW-1:0] ser_word,
  input  logic          des_push,
  input  logic [DW-1:0] des_word,
  output logic          irq,
  output logic          tx_dreq,
  output logic          rx_dreq
);
  reg_idx_e idx;
  assign idx = reg_idx_e'(bus_addr);

  // control and enable registers
  logic [THR_W-1:0] thr_q;
  logic             fl_tx_q, fl_rx_q;
  logic [7:0]       en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q   <= THR_RST;
      fl_tx_q <= 1'b0;
      fl_rx_q <= 1'b0;
      en_q    <= '0;
    end else if (bus_wr) begin
      if (idx == A_CTRL) begin
        thr_q   <= bus_wdata[THR_LSB +: THR_W];
        fl_tx_q <= bus_wdata[FL_TX];
        fl_rx_q <= bus_wdata[FL_RX];
      end
      if (idx == A_IEN) en_q <= bus_wdata[7:0] & EN_MASK;
    end
  end

  // queues
  logic [DW-1:0]  tx_head, rx_head;
  logic [TCW-1:0] tx_lvl;
  logic [RCW-1:0] rx_lvl;
  logic           tx_full, tx_empty, rx_full, rx_empty;
  logic           host_txw, host_rxr, tx_take, rx_take, rx_acc;
  logic           tx_err_evt, rx_err_evt, tx_ur_evt;

  assign host_txw   = bus_wr && (idx == A_TXD);
  assign host_rxr   = bus_rd && (idx == A_RXD);
  assign tx_take    = ser_pop && !tx_empty && !fl_tx_q;
  assign rx_take    = host_rxr && !rx_empty && !fl_rx_q;
  assign rx_acc     = des_push && !rx_full && !fl_rx_q;
  assign tx_err_evt = host_txw && (tx_full || fl_tx_q);
  assign rx_err_evt = host_rxr && !rx_take;
  assign tx_ur_evt  = ser_pop && !tx_take;

  afifo_buf #(.WIDTH(DW), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(fl_tx_q),
    .push(host_txw), .wdata(bus_wdata),
    .pop(ser_pop), .head(tx_head), .level(tx_lvl),
    .full(tx_full), .empty(tx_empty)
  );

  afifo_buf #(.WIDTH(DW), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(fl_rx_q),
    .push(des_push), .wdata(des_word),
    .pop(host_rxr), .head(rx_head), .level(rx_lvl),
    .full(rx_full), .empty(rx_empty)
  );

  // level fields
  logic [TXF_W-1:0] tx_free;
  logic [RXA_W-1:0] rx_avail;
  logic             txe_cond, rxa_cond;

  assign tx_free  = TXF_W'(TX_DEPTH) - TXF_W'(tx_lvl);
  assign rx_avail = RXA_W'(rx_lvl);
  assign txe_cond = tx_free >= {1'b0, thr_q};
  assign rxa_cond = !rx_empty;

  // status, interrupt and DMA requests
  logic [ST_W-1:0] st;

  afifo_irq u_irq (
    .clk(clk), .rst(rst),
    .txe_cond(txe_cond), .rxa_cond(rxa_cond),
    .rx_err_evt(rx_err_evt), .tx_err_evt(tx_err_evt), .tx_ur_evt(tx_ur_evt),
    .clr_we(bus_wr && (idx == A_ISTAT)), .clr_bits(bus_wdata[ST_W-1:0]),
    .en(en_q), .st(st), .irq(irq), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
  );

  // sample counters
  logic [CNT_W-1:0] tx_samp, rx_samp;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_samp <= '0;
      rx_samp <= '0;
    end else begin
      if (bus_wr && (idx == A_TXC)) tx_samp <= '0;
      else if (tx_take)             tx_samp <= tx_samp + 1'b1;
      if (bus_wr && (idx == A_RXC)) rx_samp <= '0;
      else if (rx_acc)              rx_samp <= rx_samp + 1'b1;
    end
  end

  // serializer word
  always_ff @(posedge clk) begin
    if (rst)          ser_word <= '0;
    else if (ser_pop) ser_word <= tx_take ? tx_head : '0;
  end

  // host read data
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (idx)
        A_CTRL:  bus_rdata <= {6'd0, fl_tx_q, fl_rx_q, 5'd0, thr_q, 12'd0};
        A_LVL:   bus_rdata <= {8'd0, tx_free, 10'd0, rx_avail};
        A_ISTAT: bus_rdata <= {{(DW-ST_W){1'b0}}, st};
        A_IEN:   bus_rdata <= {24'd0, en_q};
        A_TXD:   bus_rdata <= '0;
        A_RXD:   bus_rdata <= rx_take ? rx_head : '0;
        A_TXC:   bus_rdata <= DW'(tx_samp);
        default: bus_rdata <= DW'(rx_samp);
      endcase
    end
  end

  // R6
  underrun_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_pop && tx_empty) |=> (ser_word == '0));

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rxr && rx_empty) |=> (bus_rdata == '0));

  // R11
  txcnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (idx == A_TXC)) |=> (tx_samp == '0));
endmodule

// File: tb/test_audio_fifo_ctrl.sv
`timescale 1ns/1ps
module test_audio_fifo_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        ser_pop = 1'b0, des_push = 1'b0;
  logic [31:0] ser_word, des_word = '0;
  logic        irq, tx_dreq, rx_dreq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  audio_fifo_ctrl i_audio_fifo_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_pop(ser_pop), .ser_word(ser_word), .des_push(des_push),
    .des_word(des_word), .irq(irq), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v == e, req, v, e);
  endtask

  task automatic pop(output logic [31:0] w);
    @(negedge clk); ser_pop = 1'b1;
    @(negedge clk); ser_pop = 1'b0; w = ser_word;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); des_push = 1'b1; des_word = d;
    @(negedge clk); des_push = 1'b0;
  endtask

  task automatic t_reset();
    check(irq == 1'b0, "R1 irq", 32'(irq), 0);
    check(tx_dreq == 1'b0 && rx_dreq == 1'b0, "R1 dreq", {30'd0, tx_dreq, rx_dreq}, 0);
    rd_chk(3'd0, 32'h0004_0000, "R1 R12 ctrl");
    rd_chk(3'd1, 32'h0040_0000, "R1 levels");
    rd_chk(3'd3, 32'h0, "R1 enables");
    idle(2);
    rd_chk(3'd2, 32'h10, "R4 status after reset");
  endtask

  task automatic t_tx_order();
    logic [31:0] w;
    wr(3'd4, 32'h1111_1111);
    wr(3'd4, 32'h2222_2222);
    wr(3'd4, 32'h3333_3333);
    idle(2);
    rd_chk(3'd1, 32'h003D_0000, "R2 free after 3 writes");
    rd_chk(3'd2, 32'h10, "R4 sticky bit4");
    wr(3'd2, 32'h10); idle(2);
    rd_chk(3'd2, 32'h0, "R4 clear below threshold");
    pop(w); check(w == 32'h1111_1111, "R2 word0", w, 32'h1111_1111);
    pop(w); check(w == 32'h2222_2222, "R2 word1", w, 32'h2222_2222);
    pop(w); check(w == 32'h3333_3333, "R2 word2", w, 32'h3333_3333);
    idle(2);
    rd_chk(3'd1, 32'h0040_0000, "R2 free restored");
    rd_chk(3'd2, 32'h10, "R4 reset on empty");
  endtask

  task automatic t_threshold();
    wr(3'd0, 32'h0003_F000);
    rd_chk(3'd0, 32'h0003_F000, "R12 threshold readback");
    wr(3'd4, 32'hA); idle(2);
    rd_chk(3'd2, 32'h10, "R4 free63 thr63");
    wr(3'd2, 32'h10); idle(2);
    rd_chk(3'd2, 32'h10, "R4 clear ignored at threshold");
    wr(3'd4, 32'hB);
    wr(3'd2, 32'h10); idle(2);
    rd_chk(3'd2, 32'h0, "R4 clear below thr63");
    wr(3'd0, 32'h0203_F000); idle(1);
    rd_chk(3'd1, 32'h0040_0000, "R8 tx flush");
    wr(3'd0, 32'h0004_0000); idle(2);
  endtask

  task automatic t_rx();
    wr(3'd2, 32'h10);
    push(32'hCAFE_0001);
    push(32'hCAFE_0002);
    idle(2);
    rd_chk(3'd1, 32'h0040_0002, "R3 avail count");
    rd_chk(3'd2, 32'h11, "R5 rx waiting");
    rd_chk(3'd5, 32'hCAFE_0001, "R3 rx word0");
    rd_chk(3'd5, 32'hCAFE_0002, "R3 rx word1");
    idle(2);
    rd_chk(3'd1, 32'h0040_0000, "R3 drained");
    wr(3'd2, 32'h01); idle(2);
    rd_chk(3'd2, 32'h10, "R5 cleared when empty");
  endtask

  task automatic t_errors();
    logic [31:0] w;
    rd_chk(3'd5, 32'h0, "R7 empty read value");
    idle(2);
    rd_chk(3'd2, 32'h12, "R7 rx error flag");
    wr(3'd2, 32'h02);
    for (int i = 0; i < 64; i++) wr(3'd4, 32'h100 + 32'(i));
    wr(3'd4, 32'hDEAD_BEEF);
    idle(2);
    rd_chk(3'd1, 32'h0, "R7 full levels");
    rd_chk(3'd2, 32'h30, "R7 tx error flag");
    for (int i = 0; i < 64; i++) begin
      pop(w);
      check(w == 32'h100 + 32'(i), "R2 R7 full drain order", w, 32'h100 + 32'(i));
    end
    pop(w);
    check(w == 32'h0, "R6 underrun word", w, 0);
    idle(2);
    rd_chk(3'd2, 32'h70, "R6 underrun flag");
    wr(3'd2, 32'h60); idle(2);
    rd_chk(3'd2, 32'h10, "R6 R7 flags cleared");
  endtask

  task automatic t_irq();
    logic [31:0] w;
    wr(3'd3, 32'h40); idle(2);
    check(irq == 1'b0, "R9 no underrun", 32'(irq), 0);
    pop(w); idle(2);
    check(irq == 1'b1, "R9 underrun irq", 32'(irq), 1);
    wr(3'd2, 32'h40); idle(2);
    check(irq == 1'b0, "R9 underrun cleared", 32'(irq), 0);
    wr(3'd3, 32'h50); idle(2);
    check(irq == 1'b1, "R9 tx empty irq", 32'(irq), 1);
    wr(3'd3, 32'h01); idle(2);
    check(irq == 1'b0, "R9 rx idle", 32'(irq), 0);
    push(32'h5); idle(2);
    check(irq == 1'b1, "R9 rx irq", 32'(irq), 1);
    rd_chk(3'd5, 32'h5, "R3 rx single");
    wr(3'd2, 32'h01); idle(2);
    check(irq == 1'b0, "R9 rx irq cleared", 32'(irq), 0);
    wr(3'd3, 32'hFF);
    rd_chk(3'd3, 32'hD9, "R10 enable mask");
    wr(3'd3, 32'h0);
  endtask

  task automatic t_dreq();
    logic [31:0] w;
    wr(3'd3, 32'h80); idle(2);
    check(tx_dreq == 1'b1, "R10 tx dreq on", 32'(tx_dreq), 1);
    check(rx_dreq == 1'b0, "R10 rx dreq off", 32'(rx_dreq), 0);
    wr(3'd4, 32'h77); idle(2);
    check(tx_dreq == 1'b0, "R10 tx dreq below thr", 32'(tx_dreq), 0);
    pop(w);
    wr(3'd3, 32'h08);
    push(32'h9); idle(2);
    check(rx_dreq == 1'b1, "R10 rx dreq on", 32'(rx_dreq), 1);
    check(tx_dreq == 1'b0, "R10 tx dreq disabled", 32'(tx_dreq), 0);
    rd_chk(3'd5, 32'h9, "R3 rx dreq word");
    idle(2);
    check(rx_dreq == 1'b0, "R10 rx dreq off empty", 32'(rx_dreq), 0);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_counters();
    logic [31:0] w;
    rd(3'd6, w);
    check(w != 32'h0, "R11 tx counter advanced", w, 32'h1);
    wr(3'd6, 32'hFFFF);
    rd_chk(3'd6, 32'h0, "R11 tx counter reset");
    wr(3'd4, 32'h1); wr(3'd4, 32'h2);
    pop(w); pop(w);
    rd_chk(3'd6, 32'h2, "R11 tx counter two");
    wr(3'd7, 32'h0);
    push(32'hA1); push(32'hA2); push(32'hA3);
    rd_chk(3'd7, 32'h3, "R11 rx counter three");
    wr(3'd7, 32'h1234);
    rd_chk(3'd7, 32'h0, "R11 rx counter reset");
    rd_chk(3'd1, 32'h0040_0003, "R3 rx held before flush");
    wr(3'd0, 32'h0104_0000);
    wr(3'd0, 32'h0004_0000);
    rd_chk(3'd1, 32'h0040_0000, "R8 rx flush");
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    t_reset();
    t_tx_order();
    t_threshold();
    t_rx();
    t_errors();
    t_irq();
    t_dreq();
    t_counters();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule